// File: doc/BRIEF.md
# Dual-Core Masked Interrupt Aggregator

This block gathers up to 32 level-sensitive, active-high interrupt requests and fans them out to two processor cores. Each core has two outputs: an ordinary interrupt line and a machine-check line. Each of the four outputs has its own mask register. An output is high whenever at least one synchronized request is present and enabled in that output's mask. No request is latched and none has to be acknowledged. An output stays high only while some enabled source keeps its request up. The same request may be enabled in several masks, and it then drives all of those outputs at once.

Software uses a small synchronous 32-bit register port. It reads the raw synchronized levels from a status word, programs the four masks, and finds the active sources by ANDing status with a mask. The block does no priority encoding and gives no vector. Only the low 17 request positions are wired. The upper status positions are tied off.

Top module: `irq_fanout_hub`

## Requirements
- R1: After reset every mask register reads 0x00000000, status reads 0 while inputs are low, and all four outputs are low.
- R2: Byte offset 0x00 returns the synchronized request levels, which become visible two clock edges after an input changes. Bits 31..17 always read 0.
- R3: The interrupt mask of core n sits at byte offset 0x10 + 4·n (0x10 for core 0, 0x14 for core 1). It is written with the full 32-bit data word and reads back what was written. A 1 bit enables that source.
- R4: The machine-check mask of core n sits at byte offset 0x18 + 4·n (0x18 for core 0, 0x1C for core 1). It behaves like the interrupt masks.
- R5: Each output is a register holding the OR over all bits of (status AND its own mask). It changes one clock edge after status or that mask changes, so an input edge reaches an output three edges later.
- R6: A source enabled in several masks drives every one of those outputs high in the same cycle.
- R7: An output falls without any acknowledge once its sources drop (three edges after the input falls) or once they are masked off (one edge after the mask write).
- R8: A write to offset 0x00, to any unmapped offset, or to a misaligned address leaves all masks unchanged. A read of such an offset returns 0.
- R9: Read data depends only on the current address and state and is valid in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw level interrupt requests, active high |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Write enable, sampled on the rising clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational on regAddr |
| coreIrq | output | 2 | Interrupt line per core |
| coreMck | output | 2 | Machine-check line per core |

## Verification
The bench targets the cases that are easy to miss. One source is enabled in three masks at once; a design that routed each source to a single output would raise only one line. A source drops while its mask stays set; a design that latched requests would keep the output high. The bench also writes to the status offset, to a gap, and to a misaligned address. A loose address decoder would corrupt a mask or return stale data there. Finally, an all-ones input must read back as 0x0001FFFF. A reference model tracks the exact three-edge and one-edge latencies, so an extra or missing flop in the synchronizer or output stage shows up as a mismatch.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

  localparam int CORE_CNT   = 2;
  localparam int CORE_IDX_W = (CORE_CNT > 1) ? $clog2(CORE_CNT) : 1;

  // byte offsets; software decodes these, so they stay fixed
  localparam int STAT_OFS   = 'h00;
  localparam int INT_BASE   = 'h10;
  localparam int MCK_BASE   = 'h18;
  localparam int REG_STRIDE = 4;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_INT  = 2'd2,
    RD_MCK  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic [CORE_CNT-1:0]   intWe;
    logic [CORE_CNT-1:0]   mckWe;
    rd_sel_e               rdSel;
    logic [CORE_IDX_W-1:0] rdCore;
  } hub_strobe_t;

endpackage

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output hub_strobe_t       strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (regAddr == ADDR_W'(STAT_OFS)) begin
      strb.rdSel = RD_STAT;
    end
    for (int c = 0; c < CORE_CNT; c++) begin
      if (regAddr == ADDR_W'(INT_BASE + REG_STRIDE * c)) begin
        strb.intWe[c] = regWe;
        strb.rdSel    = RD_INT;
        strb.rdCore   = CORE_IDX_W'(c);
      end
      if (regAddr == ADDR_W'(MCK_BASE + REG_STRIDE * c)) begin
        strb.mckWe[c] = regWe;
        strb.rdSel    = RD_MCK;
        strb.rdCore   = CORE_IDX_W'(c);
      end
    end
  end

  // R8: at most one mask register is written per cycle
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.intWe, strb.mckWe}));

  // R8: no write strobe without a bus write
  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !regWe |-> ({strb.intWe, strb.mckWe} == '0));

endmodule

// File: rtl/irqhub_dpath.sv
module irqhub_dpath
  import irqhub_pkg::*;
#(
  parameter int SRC_W       = 32,
  parameter int LIVE_SRC    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   irqIn,
  input  logic [SRC_W-1:0]   regWdata,
  input  hub_strobe_t        strb,
  output logic [SRC_W-1:0]   rdData,
  output logic [CORE_CNT-1:0] coreIrq,
  output logic [CORE_CNT-1:0] coreMck
);

  logic [SRC_W-1:0] liveMask;
  logic [SRC_W-1:0] syncQ [SYNC_STAGES];
  logic [SRC_W-1:0] statusQ;
  logic [SRC_W-1:0] intMaskQ [CORE_CNT];
  logic [SRC_W-1:0] mckMaskQ [CORE_CNT];

  // wired source positions
  genvar b;
  generate
    for (b = 0; b < SRC_W; b++) begin : g_live
      assign liveMask[b] = (b < LIVE_SRC);
    end
  endgenerate

  // synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[0] <= '0;
          else        syncQ[0] <= irqIn & liveMask;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[s] <= '0;
          else        syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign statusQ = syncQ[SYNC_STAGES-1];

  // per-core mask registers and output flops
  genvar c;
  generate
    for (c = 0; c < CORE_CNT; c++) begin : g_core
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          intMaskQ[c] <= '0;
          mckMaskQ[c] <= '0;
          coreIrq[c]  <= 1'b0;
          coreMck[c]  <= 1'b0;
        end else begin
          if (strb.intWe[c]) intMaskQ[c] <= regWdata;
          if (strb.mckWe[c]) mckMaskQ[c] <= regWdata;
          coreIrq[c] <= |(statusQ & intMaskQ[c]);
          coreMck[c] <= |(statusQ & mckMaskQ[c]);
        end
      end

      a_r3_int_write: assert property (@(posedge clk) disable iff (!rst_n)
        strb.intWe[c] |=> (intMaskQ[c] == $past(regWdata)));

      a_r4_mck_write: assert property (@(posedge clk) disable iff (!rst_n)
        strb.mckWe[c] |=> (mckMaskQ[c] == $past(regWdata)));

      a_r8_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.intWe[c] |=> $stable(intMaskQ[c]));

      a_r8_mck_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.mckWe[c] |=> $stable(mckMaskQ[c]));

      a_r7_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((statusQ & intMaskQ[c]) == '0) |=> !coreIrq[c]);

      a_r7_mck_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((statusQ & mckMaskQ[c]) == '0) |=> !coreMck[c]);
    end
  endgenerate

  // read mux
  always_comb begin
    unique case (strb.rdSel)
      RD_STAT: rdData = statusQ;
      RD_INT:  rdData = intMaskQ[strb.rdCore];
      RD_MCK:  rdData = mckMaskQ[strb.rdCore];
      default: rdData = '0;
    endcase
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusQ & ~liveMask) == '0));

endmodule

// File: rtl/irq_fanout_hub.sv
module irq_fanout_hub
  import irqhub_pkg::*;
#(
  parameter int SRC_W       = 32,
  parameter int LIVE_SRC    = 17,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_W-1:0]    irqIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [SRC_W-1:0]    regWdata,
  output logic [SRC_W-1:0]    regRdata,
  output logic [CORE_CNT-1:0] coreIrq,
  output logic [CORE_CNT-1:0] coreMck
);

  hub_strobe_t strb;

  irqhub_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  irqhub_dpath #(
    .SRC_W       (SRC_W),
    .LIVE_SRC    (LIVE_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqIn    (irqIn),
    .regWdata (regWdata),
    .strb     (strb),
    .rdData   (regRdata),
    .coreIrq  (coreIrq),
    .coreMck  (coreMck)
  );

  // R8: unmapped reads return zero
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel == RD_NONE) |-> (regRdata == '0));

  // R2: reserved status bits read zero at the port
  a_r2_port_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_W'(STAT_OFS)) |-> ((regRdata >> LIVE_SRC) == '0));

endmodule

// File: tb/irq_fanout_hub_tb_top.sv
module irq_fanout_hub_tb_top;

  localparam logic [31:0] LIVE = 32'h0001_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irqIn = '0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  coreIrq;
  logic [1:0]  coreMck;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  irq_fanout_hub dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .coreIrq(coreIrq), .coreMck(coreMck)
  );

  // ---------------- reference model ----------------
  logic [31:0] mInt [2];
  logic [31:0] mMck [2];
  logic [31:0] mStatus;
  logic [1:0]  mIrq, mMckOut;
  logic [31:0] pipeQ [$];

  initial begin
    mInt[0] = '0; mInt[1] = '0; mMck[0] = '0; mMck[1] = '0;
    mStatus = '0; mIrq = '0; mMckOut = '0;
    pipeQ.push_back(32'h0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mInt[0] = '0; mInt[1] = '0; mMck[0] = '0; mMck[1] = '0;
      mStatus = '0; mIrq = '0; mMckOut = '0;
      pipeQ.delete();
      pipeQ.push_back(32'h0);
    end else begin
      for (int c = 0; c < 2; c++) begin
        mIrq[c]    = ((mStatus & mInt[c]) != 0);
        mMckOut[c] = ((mStatus & mMck[c]) != 0);
      end
      pipeQ.push_back(irqIn & LIVE);
      mStatus = pipeQ.pop_front();
      if (regWe) begin
        case (regAddr)
          8'h10: mInt[0] = regWdata;
          8'h14: mInt[1] = regWdata;
          8'h18: mMck[0] = regWdata;
          8'h1C: mMck[1] = regWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mStatus;
      8'h10: return mInt[0];
      8'h14: return mInt[1];
      8'h18: return mMck[0];
      8'h1C: return mMck[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycleCnt);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    cycleCnt++;
    if (rst_n && !done) begin
      case (regAddr)
        8'h00: check("R2 status read", regRdata, modelRead(regAddr));
        8'h10, 8'h14: check("R3 int mask read", regRdata, modelRead(regAddr));
        8'h18, 8'h1C: check("R4 mck mask read", regRdata, modelRead(regAddr));
        default: check("R8 unmapped read", regRdata, modelRead(regAddr));
      endcase
      check("R5 irq outputs", {30'h0, coreIrq}, {30'h0, mIrq});
      check("R5 mck outputs", {30'h0, coreMck}, {30'h0, mMckOut});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regReadChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic setIrq(input logic [31:0] v);
    @(negedge clk); #1;
    irqIn = v;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finishRun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R1: reset state
    waitEdges(1);
    check("R1 outputs after reset", {28'h0, coreIrq, coreMck}, 32'h0);
    regReadChk("R1 int0 reset", 8'h10, 32'h0);
    regReadChk("R1 int1 reset", 8'h14, 32'h0);
    regReadChk("R1 mck0 reset", 8'h18, 32'h0);
    regReadChk("R1 mck1 reset", 8'h1C, 32'h0);
    regReadChk("R1 status reset", 8'h00, 32'h0);

    // R3 / R5: core 0 interrupt routing
    regWrite(8'h10, 32'h0000_0005);
    regReadChk("R3 int0 readback", 8'h10, 32'h0000_0005);
    setIrq(32'h0000_0004);
    waitEdges(2);
    check("R5 irq0 not yet (2 edges)", {31'h0, coreIrq[0]}, 32'h0);
    waitEdges(1);
    check("R5 irq0 after 3 edges", {30'h0, coreIrq}, 32'h1);

    // R6: one source to three outputs
    regWrite(8'h1C, 32'h0000_0004);
    regWrite(8'h14, 32'h0000_0004);
    waitEdges(1);
    check("R6 fanout irq", {30'h0, coreIrq}, 32'h3);
    check("R6 fanout mck", {30'h0, coreMck}, 32'h2);
    regReadChk("R4 mck1 readback", 8'h1C, 32'h0000_0004);

    // R7: source drops without acknowledge
    setIrq(32'h0);
    waitEdges(3);
    check("R7 drop on source release", {28'h0, coreIrq, coreMck}, 32'h0);
    setIrq(32'h0000_0004);
    waitEdges(3);
    regWrite(8'h10, 32'h0);
    waitEdges(1);
    check("R7 drop on mask clear", {31'h0, coreIrq[0]}, 32'h0);

    // R2: reserved bits of status
    setIrq(32'hFFFF_FFFF);
    waitEdges(2);
    regReadChk("R2 status all ones", 8'h00, 32'h0001_FFFF);

    // R8: writes to status, gaps and misaligned offsets
    regWrite(8'h00, 32'hDEAD_BEEF);
    regWrite(8'h04, 32'hDEAD_BEEF);
    regWrite(8'h20, 32'hDEAD_BEEF);
    regWrite(8'h11, 32'hDEAD_BEEF);
    regReadChk("R8 int0 unchanged", 8'h10, 32'h0);
    regReadChk("R8 int1 unchanged", 8'h14, 32'h0000_0004);
    regReadChk("R8 mck0 unchanged", 8'h18, 32'h0);
    regReadChk("R8 gap read zero", 8'h08, 32'h0);
    regReadChk("R8 misaligned read zero", 8'h12, 32'h0);

    // R9: combinational read, no clock between address changes
    @(negedge clk); #1;
    regAddr = 8'h14; #1;
    check("R9 same-cycle read int1", regRdata, 32'h0000_0004);
    regAddr = 8'h1C; #1;
    check("R9 same-cycle read mck1", regRdata, 32'h0000_0004);

    // random traffic checked by the model every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      irqIn = $urandom();
      if (($urandom() % 3) == 0) irqIn = '0;
      regWe = (($urandom() % 4) == 0);
      case ($urandom() % 8)
        0: regAddr = 8'h00;
        1: regAddr = 8'h04;
        2: regAddr = 8'h10;
        3: regAddr = 8'h14;
        4: regAddr = 8'h18;
        5: regAddr = 8'h1C;
        6: regAddr = 8'h20;
        default: regAddr = 8'h13;
      endcase
      regWdata = $urandom() & (($urandom() % 2) ? 32'hFFFF_FFFF : 32'h0000_0011);
    end
    @(negedge clk); #1;
    regWe = 1'b0;
    waitEdges(4);
    finishRun();
  end

endmodule